// File: doc/BRIEF.md
# Halt and Active-Halt Power Controller

This block sequences the two lowest-power states of a small 8-bit microcontroller. When the CPU reports that it has executed its halt instruction, the controller puts the chip into one of two sleep depths. The depth depends on the real-time-clock interrupt-enable bit. With that bit set, a shallow sleep keeps the main oscillator and the RTC counter running. With it clear, a deep halt gates every clock. On each entry the controller writes the value 10 into the CPU's two interrupt-mask bits, so that interrupts are enabled while the chip sleeps.

Wake-up follows two paths. An RTC interrupt, or an interrupt from a wake-capable source, ends shallow sleep at once and lets the CPU service that interrupt with no delay. A wake-capable source ends deep halt only after an oscillator stabilisation period. A reset request ends any state after the same stabilisation period and then asks the CPU to fetch the reset vector. An option input picks a stabilisation period of 256 or 4096 cycles. While the chip is in shallow sleep, the controller tells the watchdog to hold off its reset.

Top module: `lp_halt_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, the block is in RUN with mode 00 and clk_en 1111. resume, vec_fetch and imask_wr are all low.
- R2: In RUN, a high `halt_exec` moves the block at the next edge to shallow sleep (mode 01) when `rtc_ie` is 1, or to deep halt (mode 10) when `rtc_ie` is 0.
- R3: On the edge that enters either sleep state, imask_wr is high for exactly one cycle and imask reads 10. At all other times imask reads 00.
- R4: clk_en has bit 3 for the CPU, bit 2 for the peripherals, bit 1 for the oscillator and bit 0 for the RTC counter. Its value is 1111 in RUN, 0011 in shallow sleep, 0000 in deep halt and 0011 in DELAY (mode 11).
- R5: In shallow sleep, `irq_rtc` or a wake-capable `irq_src` bit (default mask 0011, i.e. bits 0 and 1) returns the block to RUN at the next edge, with resume high for that one cycle and no DELAY.
- R6: irq_src bits outside the wake mask do not end shallow sleep. In deep halt, both `irq_rtc` and irq_src bits outside the mask are ignored: the mode stays unchanged.
- R7: If a wake-capable interrupt is already pending when halt is executed, the block spends exactly one cycle in shallow sleep and then returns to RUN with resume high.
- R8: In deep halt, a wake-capable irq_src bit moves the block to DELAY. When DELAY ends, the block returns to RUN with resume high and vec_fetch low.
- R9: `rst_req` moves the block to DELAY from any state. When that DELAY ends, the block returns to RUN with vec_fetch high for one cycle and resume low.
- R10: DELAY lasts exactly 256 cycles when `dly_long` was 0, and exactly 4096 cycles when it was 1. The value used is the one sampled on the edge that entered DELAY.
- R11: An `rst_req` that arrives during DELAY restarts the count from zero and takes a fresh sample of `dly_long`.
- R12: wdg_hold is high exactly while the mode is shallow sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| halt_exec | input | 1 | CPU executed the halt instruction |
| rtc_ie | input | 1 | RTC interrupt enable; selects the sleep depth |
| dly_long | input | 1 | Option: 0 gives 256 cycles, 1 gives 4096 cycles of stabilisation |
| irq_rtc | input | 1 | RTC interrupt request |
| irq_src | input | N_SRC | Other interrupt requests; WAKE_MASK marks the wake-capable ones |
| rst_req | input | 1 | Reset event that triggers the stabilised exit |
| mode | output | 2 | 00 RUN, 01 shallow sleep, 10 deep halt, 11 DELAY |
| clk_en | output | 4 | Clock enables {cpu, peripheral, oscillator, rtc} |
| resume | output | 1 | One-cycle pulse: CPU resumes by servicing the interrupt |
| vec_fetch | output | 1 | One-cycle pulse: CPU fetches the reset vector |
| imask_wr | output | 1 | One-cycle write strobe for the interrupt-mask bits |
| imask | output | 2 | Mask value written on sleep entry (10) |
| wdg_hold | output | 1 | Holds off the watchdog reset during shallow sleep |

## Verification
Every bad state decode shows on mode and clk_en at the very next edge. A stuck or miscleared stabilisation counter shows only at the end of DELAY: RUN comes early or late, or the wrong vec_fetch or resume pulse appears. DELAY is therefore probed on its last cycle and on the first cycle after it, for both lengths and for a restart in the middle. A wake source that is wrongly qualified shows as an early exit on the cycle after the ignored request, so each ignored request is followed straight away by a mode check.

// File: rtl/lp_halt_pkg.sv
package lp_halt_pkg;

  typedef enum logic [1:0] {
    M_RUN    = 2'b00,
    M_ACTIVE = 2'b01,
    M_DEEP   = 2'b10,
    M_STAB   = 2'b11
  } lp_mode_e;

  localparam int CE_W = 4;
  localparam int CE_CPU = 3;
  localparam int CE_PER = 2;
  localparam int CE_OSC = 1;
  localparam int CE_RTC = 0;

  localparam logic [1:0] IMASK_SLEEP = 2'b10;

  function automatic logic [CE_W-1:0] clk_en_of(lp_mode_e m);
    logic [CE_W-1:0] ce;
    ce = '0;
    unique case (m)
      M_RUN: ce = '1;
      M_ACTIVE, M_STAB: begin
        ce[CE_OSC] = 1'b1;
        ce[CE_RTC] = 1'b1;
      end
      default: ce = '0;
    endcase
    return ce;
  endfunction

endpackage

// File: rtl/lp_wake_filter.sv
module lp_wake_filter #(
  parameter int N_SRC = 4,
  parameter logic [N_SRC-1:0] WAKE_MASK = 4'b0011
) (
  input  logic             irq_rtc,
  input  logic [N_SRC-1:0] irq_src,
  output logic             shallow_wake,
  output logic             deep_wake
);

  logic [N_SRC-1:0] qual;

  for (genvar i = 0; i < N_SRC; i++) begin : g_qual
    if (WAKE_MASK[i]) begin : g_on
      assign qual[i] = irq_src[i];
    end else begin : g_off
      assign qual[i] = 1'b0;
    end
  end

  assign deep_wake    = |qual;
  assign shallow_wake = deep_wake | irq_rtc;

endmodule

// File: rtl/lp_stab_timer.sv
module lp_stab_timer #(
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic long_sel,
  output logic done
);

  localparam int CW = $clog2(DLY_LONG);
  localparam logic [CW-1:0] LAST_SHORT = CW'(DLY_SHORT - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(DLY_LONG - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = long_sel ? LAST_LONG : LAST_SHORT;
  assign done = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lp_halt_fsm.sv
module lp_halt_fsm
  import lp_halt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_exec,
  input  logic            rtc_ie,
  input  logic            dly_long,
  input  logic            rst_req,
  input  logic            shallow_wake,
  input  logic            deep_wake,
  input  logic            tmr_done,
  output logic            tmr_clr,
  output logic            tmr_run,
  output logic            tmr_long,
  output logic [1:0]      mode,
  output logic [CE_W-1:0] clk_en,
  output logic            resume,
  output logic            vec_fetch,
  output logic            imask_wr,
  output logic [1:0]      imask,
  output logic            wdg_hold
);

  lp_mode_e st, nxt;
  logic     cause_rst, nxt_cause;
  logic     go_dly, enter_sleep, nxt_res, nxt_vf;

  always_comb begin
    nxt         = st;
    nxt_cause   = cause_rst;
    go_dly      = 1'b0;
    enter_sleep = 1'b0;
    nxt_res     = 1'b0;
    nxt_vf      = 1'b0;
    if (rst_req) begin
      nxt       = M_STAB;
      nxt_cause = 1'b1;
      go_dly    = 1'b1;
    end else begin
      unique case (st)
        M_RUN: if (halt_exec) begin
          nxt         = rtc_ie ? M_ACTIVE : M_DEEP;
          enter_sleep = 1'b1;
        end
        M_ACTIVE: if (shallow_wake) begin
          nxt     = M_RUN;
          nxt_res = 1'b1;
        end
        M_DEEP: if (deep_wake) begin
          nxt       = M_STAB;
          nxt_cause = 1'b0;
          go_dly    = 1'b1;
        end
        default: if (tmr_done) begin
          nxt     = M_RUN;
          nxt_res = !cause_rst;
          nxt_vf  = cause_rst;
        end
      endcase
    end
  end

  assign tmr_clr = go_dly;
  assign tmr_run = (st == M_STAB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= M_RUN;
      cause_rst <= 1'b0;
      tmr_long  <= 1'b0;
      clk_en    <= clk_en_of(M_RUN);
      resume    <= 1'b0;
      vec_fetch <= 1'b0;
      imask_wr  <= 1'b0;
      imask     <= 2'b00;
      wdg_hold  <= 1'b0;
    end else begin
      st        <= nxt;
      cause_rst <= nxt_cause;
      if (go_dly) tmr_long <= dly_long;
      clk_en    <= clk_en_of(nxt);
      resume    <= nxt_res;
      vec_fetch <= nxt_vf;
      imask_wr  <= enter_sleep;
      imask     <= enter_sleep ? IMASK_SLEEP : 2'b00;
      wdg_hold  <= (nxt == M_ACTIVE);
    end
  end

  assign mode = st;

endmodule

// File: rtl/lp_halt_ctrl.sv
module lp_halt_ctrl #(
  parameter int N_SRC = 4,
  parameter logic [N_SRC-1:0] WAKE_MASK = 4'b0011,
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_exec,
  input  logic             rtc_ie,
  input  logic             dly_long,
  input  logic             irq_rtc,
  input  logic [N_SRC-1:0] irq_src,
  input  logic             rst_req,
  output logic [1:0]       mode,
  output logic [3:0]       clk_en,
  output logic             resume,
  output logic             vec_fetch,
  output logic             imask_wr,
  output logic [1:0]       imask,
  output logic             wdg_hold
);

  logic shallow_wake, deep_wake;
  logic tmr_clr, tmr_run, tmr_long, tmr_done;

  lp_wake_filter #(.N_SRC(N_SRC), .WAKE_MASK(WAKE_MASK)) u_wake (
    .irq_rtc      (irq_rtc),
    .irq_src      (irq_src),
    .shallow_wake (shallow_wake),
    .deep_wake    (deep_wake)
  );

  lp_stab_timer #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr      (tmr_clr),
    .run      (tmr_run),
    .long_sel (tmr_long),
    .done     (tmr_done)
  );

  lp_halt_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .halt_exec    (halt_exec),
    .rtc_ie       (rtc_ie),
    .dly_long     (dly_long),
    .rst_req      (rst_req),
    .shallow_wake (shallow_wake),
    .deep_wake    (deep_wake),
    .tmr_done     (tmr_done),
    .tmr_clr      (tmr_clr),
    .tmr_run      (tmr_run),
    .tmr_long     (tmr_long),
    .mode         (mode),
    .clk_en       (clk_en),
    .resume       (resume),
    .vec_fetch    (vec_fetch),
    .imask_wr     (imask_wr),
    .imask        (imask),
    .wdg_hold     (wdg_hold)
  );

endmodule

// File: rtl/lp_halt_chk.sv
module lp_halt_chk #(
  parameter int DLY_LONG = 4096
) (
  input logic       clk,
  input logic       rst,
  input logic       rst_req,
  input logic [1:0] mode,
  input logic [3:0] clk_en,
  input logic       resume,
  input logic       vec_fetch,
  input logic       imask_wr,
  input logic [1:0] imask,
  input logic       wdg_hold
);

  localparam int DW = $clog2(DLY_LONG) + 1;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst || mode != 2'b11 || rst_req) dcnt <= '0;
    else dcnt <= dcnt + 1'b1;
  end

  // R3: a sleep entry from RUN carries the mask write
  a_r3_mask_on_entry: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b00 && (mode == 2'b01 || mode == 2'b10)) |-> (imask_wr && imask == 2'b10));

  // R4: shallow sleep keeps only the oscillator and RTC clocks
  a_r4_shallow_clocks: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (clk_en == 4'b0011));

  // R4: deep halt stops every clock
  a_r4_deep_clocks: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (clk_en == 4'b0000));

  // R5: leaving shallow sleep without a reset request goes to RUN with resume
  a_r5_no_delay: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b01 && mode != 2'b01 && !$past(rst_req)) |-> (mode == 2'b00 && resume));

  // R9: reset-vector fetch only on the exit from DELAY
  a_r9_fetch_after_delay: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |-> (mode == 2'b00 && $past(mode) == 2'b11));

  // R9: resume and reset-vector fetch never together
  a_r9_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resume, vec_fetch}));

  // R10: DELAY never outlasts the long period
  a_r10_delay_bound: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |-> (dcnt < DW'(DLY_LONG)));

  // R12: watchdog hold tracks shallow sleep
  a_r12_wdg_hold: assert property (@(posedge clk) disable iff (rst)
    wdg_hold == (mode == 2'b01));

endmodule

bind lp_halt_ctrl lp_halt_chk #(.DLY_LONG(DLY_LONG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rst_req   (rst_req),
  .mode      (mode),
  .clk_en    (clk_en),
  .resume    (resume),
  .vec_fetch (vec_fetch),
  .imask_wr  (imask_wr),
  .imask     (imask),
  .wdg_hold  (wdg_hold)
);

// File: tb/sim_lp_halt_ctrl.sv
module sim_lp_halt_ctrl;

  localparam int CLK_P = 10;
  localparam int SHORT = 256;
  localparam int LONG  = 4096;

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] ce;
    logic       res;
    logic       vf;
    logic       iw;
    logic [1:0] im;
    logic       wdg;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_exec = 1'b0, rtc_ie = 1'b0, dly_long = 1'b0, irq_rtc = 1'b0, rst_req = 1'b0;
  logic [3:0] irq_src = 4'b0000;
  logic [1:0] mode, imask;
  logic [3:0] clk_en;
  logic       resume, vec_fetch, imask_wr, wdg_hold;

  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;
  exp_t q_exp[$];
  string q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  lp_halt_ctrl u0 (
    .clk(clk), .rst(rst), .halt_exec(halt_exec), .rtc_ie(rtc_ie), .dly_long(dly_long),
    .irq_rtc(irq_rtc), .irq_src(irq_src), .rst_req(rst_req), .mode(mode), .clk_en(clk_en),
    .resume(resume), .vec_fetch(vec_fetch), .imask_wr(imask_wr), .imask(imask), .wdg_hold(wdg_hold)
  );

  function automatic exp_t mk(logic [1:0] m, logic r, logic v, logic w);
    exp_t e;
    e.mode = m;
    e.ce   = (m == 2'b00) ? 4'b1111 : (m == 2'b10) ? 4'b0000 : 4'b0011;
    e.res  = r;
    e.vf   = v;
    e.iw   = w;
    e.im   = w ? 2'b10 : 2'b00;
    e.wdg  = (m == 2'b01);
    return e;
  endfunction

  task automatic drive(input logic h, input logic ie, input logic lg, input logic rtc,
                       input logic [3:0] src, input logic rr, input bit chk,
                       input exp_t e, input string tag);
    @(negedge clk);
    halt_exec = h; rtc_ie = ie; dly_long = lg; irq_rtc = rtc; irq_src = src; rst_req = rr;
    if (chk) begin
      q_exp.push_back(e);
      q_tag.push_back(tag);
    end
  endtask

  task automatic idle(input bit chk, input exp_t e, input string tag);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, chk, e, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        exp_t e;
        exp_t a;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = '{mode, clk_en, resume, vec_fetch, imask_wr, imask, wdg_hold};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s: actual mode=%b ce=%b res=%b vf=%b iw=%b im=%b wdg=%b expected mode=%b ce=%b res=%b vf=%b iw=%b im=%b wdg=%b",
                   t, a.mode, a.ce, a.res, a.vf, a.iw, a.im, a.wdg,
                   e.mode, e.ce, e.res, e.vf, e.iw, e.im, e.wdg);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual run hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle(1'b1, mk(2'b00, 0, 0, 0), "R1 under reset");
    idle(1'b0, mk(2'b00, 0, 0, 0), "R1");
    @(negedge clk); rst = 1'b0;
    idle(1'b1, mk(2'b00, 0, 0, 0), "R1 after release");

    // R2 R3 R4 R12: shallow sleep entry
    drive(1, 1, 0, 0, 4'b0000, 0, 1'b1, mk(2'b01, 0, 0, 1), "R2 R3 R4 R12 shallow entry");
    // R6: non-wake sources ignored in shallow sleep
    drive(0, 1, 0, 0, 4'b1000, 0, 1'b1, mk(2'b01, 0, 0, 0), "R6 src3 ignored");
    drive(0, 1, 0, 0, 4'b0100, 0, 1'b1, mk(2'b01, 0, 0, 0), "R6 src2 ignored");
    // R5: RTC wakes with no delay
    drive(0, 1, 0, 1, 4'b0000, 0, 1'b1, mk(2'b00, 1, 0, 0), "R5 rtc wake");
    idle(1'b1, mk(2'b00, 0, 0, 0), "R5 resume one cycle");

    // R7: pending wake at halt
    drive(1, 1, 0, 0, 4'b0001, 0, 1'b1, mk(2'b01, 0, 0, 1), "R7 enter with pending");
    drive(0, 1, 0, 0, 4'b0001, 0, 1'b1, mk(2'b00, 1, 0, 0), "R7 R5 immediate wake");
    idle(1'b1, mk(2'b00, 0, 0, 0), "R3 mask idle");

    // R2 R4: deep halt
    drive(1, 0, 0, 0, 4'b0000, 0, 1'b1, mk(2'b10, 0, 0, 1), "R2 R3 R4 deep entry");
    drive(0, 0, 0, 1, 4'b0000, 0, 1'b1, mk(2'b10, 0, 0, 0), "R6 rtc ignored deep");
    drive(0, 0, 0, 0, 4'b1100, 0, 1'b1, mk(2'b10, 0, 0, 0), "R6 src ignored deep");
    // R8: deep wake through short delay
    drive(0, 0, 0, 0, 4'b0010, 0, 1'b1, mk(2'b11, 0, 0, 0), "R8 R4 deep to delay");
    for (int i = 1; i <= SHORT; i++) begin
      if (i == SHORT - 1) idle(1'b1, mk(2'b11, 0, 0, 0), "R10 short last delay cycle");
      else if (i == SHORT) idle(1'b1, mk(2'b00, 1, 0, 0), "R8 R10 short exit resume");
      else idle(1'b0, mk(2'b00, 0, 0, 0), "");
    end

    // R9: reset request from shallow sleep, long delay
    drive(1, 1, 0, 0, 4'b0000, 0, 1'b1, mk(2'b01, 0, 0, 1), "R2 shallow again");
    drive(0, 0, 1, 0, 4'b0000, 1, 1'b1, mk(2'b11, 0, 0, 0), "R9 reset to delay");
    for (int i = 1; i <= LONG; i++) begin
      if (i == LONG - 1) idle(1'b1, mk(2'b11, 0, 0, 0), "R10 long last delay cycle");
      else if (i == LONG) idle(1'b1, mk(2'b00, 0, 1, 0), "R9 R10 long exit fetch");
      else idle(1'b0, mk(2'b00, 0, 0, 0), "");
    end
    idle(1'b1, mk(2'b00, 0, 0, 0), "R9 fetch one cycle");

    // R11: restart during DELAY, new option sample
    drive(0, 0, 1, 0, 4'b0000, 1, 1'b1, mk(2'b11, 0, 0, 0), "R9 reset from run");
    for (int i = 1; i <= 100; i++) idle(1'b0, mk(2'b00, 0, 0, 0), "");
    drive(0, 0, 0, 0, 4'b0000, 1, 1'b1, mk(2'b11, 0, 0, 0), "R11 restart");
    for (int i = 1; i <= SHORT; i++) begin
      if (i == SHORT - 1) idle(1'b1, mk(2'b11, 0, 0, 0), "R11 R10 restart last cycle");
      else if (i == SHORT) idle(1'b1, mk(2'b00, 0, 1, 0), "R11 R9 restart exit fetch");
      else idle(1'b0, mk(2'b00, 0, 0, 0), "");
    end
    idle(1'b1, mk(2'b00, 0, 0, 0), "R1 back in run");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule